// File: doc/BRIEF.md
# Floating-Point Coprocessor Issue Interlock

This block sits beside the first execute stage of an integer core and decides, cycle by cycle, whether the floating-point instruction offered there may go to the coprocessor. It keeps a scoreboard of the busy periods of three shared resources: the multiply-add unit, the divide/square-root unit, and a load/store path with three slots. It also keeps one countdown for each register that a previously issued instruction is still producing. An offered instruction is held back if it collides with a busy resource, if a source register is not ready yet, or if it is the serializing flag transfer and an arithmetic unit is still working.

The core presents the instruction class, two source register numbers and a destination register number with a valid flag, along with its own stall signal. The block answers with issue (the instruction leaves this cycle and its reservations take effect from the next edge) or stall (it must be offered again). Most results reach arithmetic consumers one cycle earlier through forwarding. The block therefore applies a separate readiness threshold for arithmetic consumers and for stores.

Top module: `fpil_issue_ctl`

## Requirements
- R1: After reset no resource is reserved and no register is pending, so the first offered instruction of any class issues in its first cycle.
- R2: While core_stall_i is high, issue_o and stall_o are both low, and busy periods keep counting down.
- R3: stall_o is high only when valid_i is high and core_stall_i is low. issue_o and stall_o are never high together. An offered instruction with no hazard issues in the same cycle.
- R4: Class 0 (arithmetic, also fast ops and conversions) holds the multiply-add unit in its issue cycle only. Its result is ready 5 cycles after issue for a store, and 4 cycles after issue for an arithmetic-class consumer (classes 0 to 3). Both src_a_i and src_b_i are checked.
- R5: Class 1 (double multiply) holds the multiply-add unit for its issue cycle and the next one. Its latency is 6, or 5 to an arithmetic consumer.
- R6: Class 2 (single divide/sqrt) holds the divide unit for 14 cycles. Its latency is 18, or 17 to an arithmetic consumer.
- R7: Class 3 (double divide/sqrt) holds the divide unit for 28 cycles and the multiply-add unit for its issue cycle. Its latency is 32, or 31 to an arithmetic consumer.
- R8: Class 4 (flag transfer) issues only in a cycle in which neither the multiply-add unit nor the divide unit is still reserved.
- R9: Class 5 (single load or core-to-FP move) uses slot 1 in its issue cycle and slot 2 in the next. Its latency is 4, or 3 to an arithmetic consumer. Class 7 (single store) uses the same slots.
- R10: Class 6 (double load) and class 8 (double store) use slots 1, 2 and 3 in the issue cycle, slots 2 and 3 in the next cycle, and slot 3 in the one after. A double load has latency 5, or 4 to an arithmetic consumer. A single load followed by a double load stalls 1 cycle. Two double loads back to back stall 2 cycles.
- R11: When several hazards hold at once, the instruction stays stalled until the last one clears.
- R12: Loads (classes 5, 6) and the flag transfer ignore both source fields. Stores (classes 7, 8) check only src_a_i. Codes 9 to 15 use no resource and check no source.
- R13: A register written again while a longer result is still pending keeps the longer remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is offered |
| op_i | input | 4 | Instruction class code |
| src_a_i | input | REG_W | First source register |
| src_b_i | input | REG_W | Second source register |
| dst_i | input | REG_W | Destination register |
| core_stall_i | input | 1 | Core is stalled in its first execute stage |
| issue_o | output | 1 | Instruction issues this cycle |
| stall_o | output | 1 | Offered instruction is held by a hazard |

## Verification
The assertions check the following on every cycle: issue and stall are exclusive and gated by valid and the core stall; a flag transfer never issues into a busy arithmetic unit; no unit or slot is granted while already reserved; and the per-register and per-unit counts decay or reload as required. The exact stall lengths can only be shown by the bench scenarios. These include the forwarded and unforwarded latencies of every producer, the staggered slot stalls between single and double transfers, the drain wait of the flag transfer, a combination of hazards that clear at different times, and a rewritten register that keeps its longer count.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

  localparam int LAT_W   = 6;
  localparam int FMAC_W  = 2;
  localparam int DS_W    = 5;
  localparam int LS_N    = 3;

  localparam int LAT_ARITH = 5;
  localparam int LAT_MULD  = 6;
  localparam int LAT_DIVS  = 18;
  localparam int LAT_DIVD  = 32;
  localparam int LAT_LDS   = 4;
  localparam int LAT_LDD   = 5;
  localparam int HOLD_DIVS = 14;
  localparam int HOLD_DIVD = 28;

  typedef enum logic [3:0] {
    OP_ARITH  = 4'd0,
    OP_MULD   = 4'd1,
    OP_DIVS   = 4'd2,
    OP_DIVD   = 4'd3,
    OP_FLAGX  = 4'd4,
    OP_LOADS  = 4'd5,
    OP_LOADD  = 4'd6,
    OP_STORES = 4'd7,
    OP_STORED = 4'd8
  } fp_op_e;

  typedef struct packed {
    logic              use_a;
    logic              use_b;
    logic              wr_dst;
    logic              arith_cons;
    logic              flag_sync;
    logic [FMAC_W-1:0] fmac_hold;
    logic [DS_W-1:0]   ds_hold;
    logic [LS_N-1:0]   ls_m0;
    logic [LS_N-1:0]   ls_m1;
    logic [LS_N-1:0]   ls_m2;
    logic [LAT_W-1:0]  lat;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [3:0] op);
    op_info_t d;
    d = '0;
    unique case (op)
      OP_ARITH, OP_MULD, OP_DIVS, OP_DIVD: begin
        d.use_a      = 1'b1;
        d.use_b      = 1'b1;
        d.wr_dst     = 1'b1;
        d.arith_cons = 1'b1;
        case (op)
          OP_ARITH: begin d.fmac_hold = FMAC_W'(1); d.lat = LAT_W'(LAT_ARITH); end
          OP_MULD:  begin d.fmac_hold = FMAC_W'(2); d.lat = LAT_W'(LAT_MULD); end
          OP_DIVS:  begin d.ds_hold = DS_W'(HOLD_DIVS); d.lat = LAT_W'(LAT_DIVS); end
          default:  begin
            d.fmac_hold = FMAC_W'(1);
            d.ds_hold   = DS_W'(HOLD_DIVD);
            d.lat       = LAT_W'(LAT_DIVD);
          end
        endcase
      end
      OP_FLAGX: d.flag_sync = 1'b1;
      OP_LOADS, OP_STORES: begin
        d.ls_m0 = 3'b001;
        d.ls_m1 = 3'b010;
        if (op == OP_LOADS) begin d.wr_dst = 1'b1; d.lat = LAT_W'(LAT_LDS); end
        else d.use_a = 1'b1;
      end
      OP_LOADD, OP_STORED: begin
        d.ls_m0 = 3'b111;
        d.ls_m1 = 3'b110;
        d.ls_m2 = 3'b100;
        if (op == OP_LOADD) begin d.wr_dst = 1'b1; d.lat = LAT_W'(LAT_LDD); end
        else d.use_a = 1'b1;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/fpil_unit_busy.sv
module fpil_unit_busy #(
  parameter int HOLD_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              busy_o
);

  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= hold_i - HOLD_W'(1);
    else if (cnt_q != '0)       cnt_q <= cnt_q - HOLD_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R5 R6: a unit is never granted while reserved
  p_no_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

  p_decay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - HOLD_W'(1)));

endmodule

// File: rtl/fpil_ls_slots.sv
module fpil_ls_slots #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] m0_i,
  input  logic [N-1:0] m1_i,
  input  logic [N-1:0] m2_i,
  output logic         clash_o
);

  // r0: slots taken in the current cycle, r1: slots taken in the next
  logic [N-1:0] r0_q, r1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r0_q <= '0;
      r1_q <= '0;
    end else if (start_i) begin
      r0_q <= r1_q | m1_i;
      r1_q <= m2_i;
    end else begin
      r0_q <= r1_q;
      r1_q <= '0;
    end
  end

  assign clash_o = |(m0_i & r0_q) | |(m1_i & r1_q);

  p_slot_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ((r0_q & $past(m1_i)) == $past(m1_i)));

endmodule

// File: rtl/fpil_reg_score.sv
module fpil_reg_score #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int LAT_W    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_idx_i,
  input  logic [LAT_W-1:0] wr_lat_i,
  input  logic [REG_W-1:0] rd_a_i,
  input  logic [REG_W-1:0] rd_b_i,
  output logic [LAT_W-1:0] cnt_a_o,
  output logic [LAT_W-1:0] cnt_b_o
);

  logic [LAT_W-1:0] cnt_q [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic             hit;
    logic [LAT_W-1:0] dec;
    assign hit = wr_i && (wr_idx_i == REG_W'(gi));
    assign dec = (cnt_q[gi] != '0) ? cnt_q[gi] - LAT_W'(1) : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        cnt_q[gi] <= '0;
      else if (hit && (wr_lat_i > dec))   cnt_q[gi] <= wr_lat_i;
      else                                cnt_q[gi] <= dec;
    end

    p_waw_keep_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && (cnt_q[gi] > wr_lat_i)) |=> (cnt_q[gi] == $past(cnt_q[gi]) - LAT_W'(1)));

    p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && (cnt_q[gi] <= wr_lat_i)) |=> (cnt_q[gi] == $past(wr_lat_i)));
  end

  assign cnt_a_o = cnt_q[rd_a_i];
  assign cnt_b_o = cnt_q[rd_b_i];

endmodule

// File: rtl/fpil_issue_ctl.sv
module fpil_issue_ctl
  import fpil_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             core_stall_i,
  output logic             issue_o,
  output logic             stall_o
);

  op_info_t         info;
  logic [LAT_W-1:0] cnt_a, cnt_b, wr_lat;
  logic             fmac_busy, ds_busy, ls_clash;
  logic             dep_a, dep_b, h_fmac, h_ds, h_flag, hazard, live;
  logic             fmac_start, ds_start, ls_start, wr_en;

  assign info = decode_op(op_i);

  // arithmetic consumers take the forwarded result one cycle early
  assign dep_a  = info.use_a && (info.arith_cons ? (cnt_a > LAT_W'(1)) : (cnt_a != '0));
  assign dep_b  = info.use_b && (info.arith_cons ? (cnt_b > LAT_W'(1)) : (cnt_b != '0));
  assign h_fmac = (info.fmac_hold != '0) && fmac_busy;
  assign h_ds   = (info.ds_hold != '0) && ds_busy;
  assign h_flag = info.flag_sync && (fmac_busy || ds_busy);
  assign hazard = dep_a || dep_b || h_fmac || h_ds || h_flag || ls_clash;

  assign live    = valid_i && !core_stall_i;
  assign issue_o = live && !hazard;
  assign stall_o = live && hazard;

  assign fmac_start = issue_o && (info.fmac_hold != '0);
  assign ds_start   = issue_o && (info.ds_hold != '0);
  assign ls_start   = issue_o && (info.ls_m0 != '0);
  assign wr_en      = issue_o && info.wr_dst;
  assign wr_lat     = info.lat - LAT_W'(1);

  fpil_reg_score #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .LAT_W    (LAT_W)
  ) u_score (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en),
    .wr_idx_i (dst_i),
    .wr_lat_i (wr_lat),
    .rd_a_i   (src_a_i),
    .rd_b_i   (src_b_i),
    .cnt_a_o  (cnt_a),
    .cnt_b_o  (cnt_b)
  );

  fpil_unit_busy #(.HOLD_W(FMAC_W)) u_fmac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fmac_start),
    .hold_i  (info.fmac_hold),
    .busy_o  (fmac_busy)
  );

  fpil_unit_busy #(.HOLD_W(DS_W)) u_ds (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ds_start),
    .hold_i  (info.ds_hold),
    .busy_o  (ds_busy)
  );

  fpil_ls_slots #(.N(LS_N)) u_ls (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ls_start),
    .m0_i    (info.ls_m0),
    .m1_i    (info.ls_m1),
    .m2_i    (info.ls_m2),
    .clash_o (ls_clash)
  );

  p_flag_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && (op_i == OP_FLAGX)) |-> (!fmac_busy && !ds_busy));

  p_core_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_stall_i |-> (!issue_o && !stall_o));

  p_stall_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (valid_i && !issue_o));

  p_src_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && info.use_a) |-> (cnt_a <= LAT_W'(1)));

endmodule

// File: tb/sim_fpil_issue_ctl.sv
`timescale 1ns/1ps
module sim_fpil_issue_ctl;
  import fpil_pkg::*;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [4:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic       core_stall_i = 1'b0;
  logic       issue_o, stall_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  fpil_issue_ctl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
    .core_stall_i(core_stall_i), .issue_o(issue_o), .stall_o(stall_o)
  );

  typedef struct packed {
    fp_op_e     op1;
    logic [4:0] d1;
    fp_op_e     op2;
    logic [4:0] a2;
    logic [4:0] b2;
    logic [5:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{OP_ARITH,  5'd3, OP_ARITH,  5'd3, 5'd9, 6'd3,  4'd4},  // R4 forwarded
    '{OP_ARITH,  5'd3, OP_ARITH,  5'd9, 5'd3, 6'd3,  4'd4},  // R4 second source
    '{OP_ARITH,  5'd3, OP_STORES, 5'd3, 5'd9, 6'd4,  4'd4},  // R4 store
    '{OP_ARITH,  5'd3, OP_ARITH,  5'd7, 5'd8, 6'd0,  4'd4},
    '{OP_MULD,   5'd3, OP_ARITH,  5'd7, 5'd8, 6'd1,  4'd5},  // R5 unit busy
    '{OP_MULD,   5'd3, OP_ARITH,  5'd3, 5'd8, 6'd4,  4'd5},
    '{OP_MULD,   5'd3, OP_STORES, 5'd3, 5'd8, 6'd5,  4'd5},
    '{OP_DIVS,   5'd3, OP_DIVS,   5'd7, 5'd8, 6'd13, 4'd6},  // R6
    '{OP_DIVS,   5'd3, OP_ARITH,  5'd3, 5'd8, 6'd16, 4'd6},
    '{OP_DIVS,   5'd3, OP_STORES, 5'd3, 5'd8, 6'd17, 4'd6},
    '{OP_DIVD,   5'd3, OP_ARITH,  5'd7, 5'd8, 6'd0,  4'd7},  // R7
    '{OP_DIVD,   5'd3, OP_DIVS,   5'd7, 5'd8, 6'd27, 4'd7},
    '{OP_DIVD,   5'd3, OP_ARITH,  5'd3, 5'd8, 6'd30, 4'd7},
    '{OP_DIVD,   5'd3, OP_STORED, 5'd3, 5'd8, 6'd31, 4'd7},
    '{OP_ARITH,  5'd3, OP_FLAGX,  5'd3, 5'd3, 6'd0,  4'd8},  // R8
    '{OP_MULD,   5'd3, OP_FLAGX,  5'd3, 5'd3, 6'd1,  4'd8},
    '{OP_DIVS,   5'd3, OP_FLAGX,  5'd3, 5'd3, 6'd13, 4'd8},
    '{OP_DIVD,   5'd3, OP_FLAGX,  5'd3, 5'd3, 6'd27, 4'd8},
    '{OP_LOADS,  5'd3, OP_ARITH,  5'd3, 5'd8, 6'd2,  4'd9},  // R9
    '{OP_LOADS,  5'd3, OP_STORES, 5'd3, 5'd8, 6'd3,  4'd9},
    '{OP_LOADS,  5'd3, OP_LOADS,  5'd7, 5'd8, 6'd0,  4'd9},
    '{OP_LOADS,  5'd3, OP_LOADD,  5'd7, 5'd8, 6'd1,  4'd10}, // R10
    '{OP_LOADD,  5'd3, OP_LOADD,  5'd7, 5'd8, 6'd2,  4'd10},
    '{OP_LOADD,  5'd3, OP_ARITH,  5'd3, 5'd8, 6'd3,  4'd10},
    '{OP_LOADD,  5'd3, OP_STORES, 5'd3, 5'd8, 6'd4,  4'd10},
    '{OP_STORED, 5'd3, OP_LOADS,  5'd7, 5'd8, 6'd0,  4'd10},
    '{OP_STORES, 5'd3, OP_LOADD,  5'd7, 5'd8, 6'd1,  4'd10},
    '{OP_LOADS,  5'd3, OP_LOADS,  5'd3, 5'd3, 6'd0,  4'd12}, // R12 loads ignore sources
    '{OP_ARITH,  5'd3, OP_STORES, 5'd7, 5'd3, 6'd0,  4'd12}  // R12 store ignores src_b
  };

  task automatic do_reset();
    valid_i = 1'b0;
    core_stall_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // call at a falling edge; returns at the falling edge after the issue cycle
  task automatic send(input fp_op_e op, input logic [4:0] a, input logic [4:0] b,
                      input logic [4:0] d, input int exp, input int req);
    int  s = 0;
    bit  bad = 1'b0;
    valid_i = 1'b1; op_i = op; src_a_i = a; src_b_i = b; dst_i = d;
    #1;
    while (!issue_o && s < 64) begin
      if (!stall_o) bad = 1'b1;
      s++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    valid_i = 1'b0;
    checks++;
    if (s != exp || bad) begin
      errors++;
      $display("FAIL R%0d op %0d: stall cycles %0d (stall_o gap %0d) expected %0d",
               req, op, s, bad, exp);
    end
  endtask

  task automatic check_out(input logic ei, input logic es, input int req);
    checks++;
    if (issue_o !== ei || stall_o !== es) begin
      errors++;
      $display("FAIL R%0d: issue %b stall %b expected %b %b", req, issue_o, stall_o, ei, es);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state, R3 idle outputs
    #1 check_out(1'b0, 1'b0, 1);
    @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      do_reset();
      send(fp_op_e'(k), 5'd1, 5'd2, 5'd4, 0, 1);  // R1 every class issues at once
    end

    for (int i = 0; i < NV; i++) begin
      do_reset();
      send(VECS[i].op1, 5'd20, 5'd21, VECS[i].d1, 0, int'(VECS[i].req));
      send(VECS[i].op2, VECS[i].a2, VECS[i].b2, 5'd12, int'(VECS[i].exp), int'(VECS[i].req));
    end

    // R2 core stall blocks both outputs, counts keep running
    do_reset();
    send(OP_MULD, 5'd1, 5'd2, 5'd3, 0, 2);
    valid_i = 1'b1; op_i = OP_ARITH; src_a_i = 5'd7; src_b_i = 5'd8; core_stall_i = 1'b1;
    #1 check_out(1'b0, 1'b0, 2);
    @(negedge clk);
    core_stall_i = 1'b0;
    send(OP_ARITH, 5'd7, 5'd8, 5'd9, 0, 2);

    // R3 hazard without valid shows no stall; with valid it stalls
    do_reset();
    send(OP_DIVS, 5'd1, 5'd2, 5'd3, 0, 3);
    op_i = OP_DIVS; valid_i = 1'b0;
    #1 check_out(1'b0, 1'b0, 3);
    valid_i = 1'b1;
    #1 check_out(1'b0, 1'b1, 3);
    @(negedge clk);
    valid_i = 1'b0;

    // R11 register clears first, divide unit last
    do_reset();
    send(OP_DIVS,  5'd1, 5'd2, 5'd5, 0, 11);
    send(OP_ARITH, 5'd1, 5'd2, 5'd6, 0, 11);
    send(OP_DIVS,  5'd6, 5'd2, 5'd7, 12, 11);

    // R13 shorter rewrite keeps the divide's count
    do_reset();
    send(OP_DIVS,   5'd1, 5'd2, 5'd5, 0, 13);
    send(OP_ARITH,  5'd1, 5'd2, 5'd5, 0, 13);
    send(OP_STORES, 5'd5, 5'd2, 5'd0, 16, 13);

    // R12 undefined codes issue next to a busy divide unit
    do_reset();
    send(OP_DIVD, 5'd1, 5'd2, 5'd3, 0, 12);
    send(fp_op_e'(4'd12), 5'd3, 5'd3, 5'd3, 0, 12);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule